// File: doc/BRIEF.md
# Chroma Plane Intra Predictor

This block produces the gradient (plane) prediction for one 8x8 chroma block. After a start strobe it captures eight samples from the row above the block, eight samples from the column to its left and the single sample at the above-left corner, all unsigned 8-bit. From weighted differences of those neighbours it derives a horizontal and a vertical gradient. It scales them into two slope coefficients and forms a base level from the two far-end neighbours. It then delivers the predicted block one row of eight pixels per clock.

The control is a three-state machine. `S_IDLE` waits for `start` and moves to `S_CALC` when `start` is seen (transition "accept"). `S_CALC` lasts one cycle. It registers the slopes and the starting row value, then always moves to `S_ROWS` (transition "launch"). `S_ROWS` holds for eight cycles, stepping the row counter 0..7 ("advance"). After row 7 it returns to `S_IDLE` ("finish"). A `start` seen outside `S_IDLE` has no effect. Each row value is built by adding the vertical slope to the previous row's accumulator. Each pixel in a row is that accumulator plus the horizontal slope times the column index.

Top module: `chroma_plane_pred`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `row_valid`, `done` and `busy` are low.
- R2: The horizontal gradient is H = 4·(t7−k) + 3·(t6−t0) + 2·(t5−t1) + 1·(t4−t2), where tN is byte N of `above_in` (bits 8N+7:8N) and k is `corner_in`.
- R3: The vertical gradient V uses the same weights on `left_in` bytes (byte N is the sample N rows down), with the corner paired with byte 7 at weight 4.
- R4: The slopes are b = (17·H + 16) >> 5 and c = (17·V + 16) >> 5, with the shift arithmetic, so negative gradients round toward minus infinity.
- R5: Pixel (x, y) equals (16·(t7 + l7) + b·(x−3) + c·(y−3) + 16) >> 5, where x is the column and y the row, both 0..7. Column x is carried on `row_pix` bits 8x+7:8x.
- R6: Each pixel is clipped to the range 0..255 after the shift.
- R7: `start` is sampled on a rising edge while idle. One cycle later, `row_valid` goes high with `row_idx` = 0, and rows 1..7 follow on consecutive cycles.
- R8: `done` is high only in the cycle that carries row 7.
- R9: Neighbour inputs are captured only when `start` is accepted. A `start` or a change of inputs while busy has no effect on the rows in flight, and it starts no new block.
- R10: `busy` is high from the cycle after an accepted `start` through the row-7 cycle, and low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block; accepted only when idle |
| above_in | input | 64 | Eight above samples, byte N = column N |
| left_in | input | 64 | Eight left samples, byte N = row N |
| corner_in | input | 8 | Above-left corner sample |
| row_valid | output | 1 | `row_pix` carries a predicted row |
| row_idx | output | 3 | Index of the row on `row_pix` |
| row_pix | output | 64 | Eight predicted pixels, byte x = column x |
| done | output | 1 | High with the last row |
| busy | output | 1 | Block in progress |

## Verification
On every cycle, the assertions check the sequencing. Rows follow one another with rising indices, and the first row comes one cycle after the calculation state. They also check that `done` coincides with row 7, that the machine falls idle right after it, that a `start` during a block does not disturb it, and that the captured neighbours stay frozen while busy. The pixel arithmetic can only be shown by the bench's scenarios, which cover rounding of negative slopes, saturation at both ends of the pixel range and flat neighbours. They compare every row against an independent model. The same applies to whether a mid-block `start` with new data leaves the output unchanged.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
    localparam int PIX_W     = 8;
    localparam int NPIX      = 8;
    localparam int ROW_W     = NPIX * PIX_W;
    localparam int IDX_W     = $clog2(NPIX);
    localparam int GRAD_W    = 16;
    localparam int COEF_W    = 16;
    localparam int ACC_W     = 20;
    localparam int SHIFT     = 5;
    localparam int GRAD_MUL  = 17;
    localparam int ROUND     = 1 << (SHIFT - 1);
    localparam int BASE_MUL  = 16;
    localparam int ORIGIN    = NPIX / 2 - 1;
    localparam int PIX_MAX   = (1 << PIX_W) - 1;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CALC = 2'd1,
        S_ROWS = 2'd2
    } cpp_state_e;

    // Weighted symmetric difference around the edge centre; the far
    // partner of the outermost sample is the corner.
    function automatic logic signed [GRAD_W-1:0] weighted_grad(
        input logic [ROW_W-1:0] edge_s,
        input logic [PIX_W-1:0] corner
    );
        int acc;
        acc = 0;
        for (int k = 1; k <= NPIX / 2; k++) begin
            int hi_v;
            int lo_v;
            hi_v = int'(edge_s[(ORIGIN + k) * PIX_W +: PIX_W]);
            if (ORIGIN - k < 0)
                lo_v = int'(corner);
            else
                lo_v = int'(edge_s[(ORIGIN - k) * PIX_W +: PIX_W]);
            acc += k * (hi_v - lo_v);
        end
        return GRAD_W'(acc);
    endfunction

    function automatic logic signed [COEF_W-1:0] scale_grad(
        input logic signed [GRAD_W-1:0] g
    );
        int t;
        t = GRAD_MUL * int'(g) + ROUND;
        return COEF_W'(t >>> SHIFT);
    endfunction

    function automatic logic [PIX_W-1:0] clip_pix(
        input logic signed [ACC_W-1:0] s
    );
        logic signed [ACC_W-1:0] q;
        q = s >>> SHIFT;
        if (q < 0)
            return '0;
        else if (q > PIX_MAX)
            return PIX_W'(PIX_MAX);
        else
            return q[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/cpp_grad.sv
module cpp_grad
    import cpp_pkg::*;
(
    input  logic [ROW_W-1:0]         above_s,
    input  logic [ROW_W-1:0]         left_s,
    input  logic [PIX_W-1:0]         corner_s,
    output logic signed [COEF_W-1:0] coef_b,
    output logic signed [COEF_W-1:0] coef_c,
    output logic signed [ACC_W-1:0]  base0
);
    logic signed [GRAD_W-1:0] grad_h;
    logic signed [GRAD_W-1:0] grad_v;
    int                       level_a;
    int                       base_i;

    always_comb begin
        grad_h  = weighted_grad(above_s, corner_s);
        grad_v  = weighted_grad(left_s, corner_s);
        coef_b  = scale_grad(grad_h);
        coef_c  = scale_grad(grad_v);
        level_a = BASE_MUL * (int'(above_s[(NPIX-1)*PIX_W +: PIX_W])
                            + int'(left_s[(NPIX-1)*PIX_W +: PIX_W]));
        base_i  = level_a - ORIGIN * int'(coef_b) - ORIGIN * int'(coef_c) + ROUND;
        base0   = ACC_W'(base_i);
    end
endmodule

// File: rtl/cpp_row.sv
module cpp_row
    import cpp_pkg::*;
(
    input  logic signed [ACC_W-1:0]  row_acc,
    input  logic signed [COEF_W-1:0] coef_b,
    output logic [ROW_W-1:0]         row_pix
);
    for (genvar gx = 0; gx < NPIX; gx++) begin : g_col
        int col_sum;
        always_comb begin
            col_sum = int'(row_acc) + gx * int'(coef_b);
            row_pix[gx*PIX_W +: PIX_W] = clip_pix(ACC_W'(col_sum));
        end
    end
endmodule

// File: rtl/cpp_ctrl.sv
module cpp_ctrl
    import cpp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             accept,
    output logic             in_calc,
    output logic             row_valid,
    output logic [IDX_W-1:0] row_idx,
    output logic             done,
    output logic             busy
);
    cpp_state_e       state_q, state_d;
    logic [IDX_W-1:0] row_q;
    logic             last_row;

    assign last_row = (row_q == IDX_W'(NPIX - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_CALC;
            S_CALC: state_d = S_ROWS;
            S_ROWS: if (last_row) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_CALC)
                row_q <= '0;
            else if (state_q == S_ROWS)
                row_q <= row_q + IDX_W'(1);
        end
    end

    always_comb begin
        accept    = 1'b0;
        in_calc   = 1'b0;
        row_valid = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            S_CALC: in_calc = 1'b1;
            S_ROWS: begin
                row_valid = 1'b1;
                done      = last_row;
            end
            default: busy = 1'b0;
        endcase
    end
    assign row_idx = row_q;

    p_done_last_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (row_valid && row_idx == IDX_W'(NPIX - 1)));

    p_row_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && !done) |=> (row_valid && row_idx == $past(row_idx) + IDX_W'(1)));

    p_first_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !row_valid) |=> (row_valid && row_idx == '0));

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy);
endmodule

// File: rtl/chroma_plane_pred.sv
module chroma_plane_pred
    import cpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  above_in,
    input  logic [ROW_W-1:0]  left_in,
    input  logic [PIX_W-1:0]  corner_in,
    output logic              row_valid,
    output logic [IDX_W-1:0]  row_idx,
    output logic [ROW_W-1:0]  row_pix,
    output logic              done,
    output logic              busy
);
    logic                     accept;
    logic                     in_calc;
    logic [ROW_W-1:0]         above_q;
    logic [ROW_W-1:0]         left_q;
    logic [PIX_W-1:0]         corner_q;
    logic signed [COEF_W-1:0] b_comb, c_comb;
    logic signed [ACC_W-1:0]  base_comb;
    logic signed [COEF_W-1:0] b_q, c_q;
    logic signed [ACC_W-1:0]  acc_q;

    cpp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .accept    (accept),
        .in_calc   (in_calc),
        .row_valid (row_valid),
        .row_idx   (row_idx),
        .done      (done),
        .busy      (busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            above_q  <= '0;
            left_q   <= '0;
            corner_q <= '0;
        end else if (accept) begin
            above_q  <= above_in;
            left_q   <= left_in;
            corner_q <= corner_in;
        end
    end

    cpp_grad u_grad (
        .above_s  (above_q),
        .left_s   (left_q),
        .corner_s (corner_q),
        .coef_b   (b_comb),
        .coef_c   (c_comb),
        .base0    (base_comb)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q   <= '0;
            c_q   <= '0;
            acc_q <= '0;
        end else if (in_calc) begin
            b_q   <= b_comb;
            c_q   <= c_comb;
            acc_q <= base_comb;
        end else if (row_valid) begin
            acc_q <= acc_q + ACC_W'(c_q);
        end
    end

    cpp_row u_row (
        .row_acc (acc_q),
        .coef_b  (b_q),
        .row_pix (row_pix)
    );

    p_capture_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(above_q) && $stable(left_q) && $stable(corner_q)));

    p_slopes_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |=> ($stable(b_q) && $stable(c_q)));
endmodule

// File: tb/chroma_plane_pred_tb.sv
module chroma_plane_pred_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [63:0] above_in;
    logic [63:0] left_in;
    logic [7:0]  corner_in;
    logic        row_valid;
    logic [2:0]  row_idx;
    logic [63:0] row_pix;
    logic        done;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    chroma_plane_pred u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .above_in  (above_in),
        .left_in   (left_in),
        .corner_in (corner_in),
        .row_valid (row_valid),
        .row_idx   (row_idx),
        .row_pix   (row_pix),
        .done      (done),
        .busy      (busy)
    );

    // {above, left, corner}
    localparam int NVEC = 6;
    localparam logic [135:0] VEC [NVEC] = '{
        {64'h6464646464646464, 64'h6464646464646464, 8'h64},  // flat
        {64'h50463C32281E140A, 64'hA08C7864503C2814, 8'h00},  // rising ramps
        {64'hFFF0E0D0C0B0A090, 64'hFFFAF0E0D0C8C0B0, 8'h10},  // saturate high
        {64'h0A1E32465A6E82FA, 64'h05142840506478F0, 8'hFF},  // negative slopes, clip low
        {64'h3355779911EE22CC, 64'h8017A04C2D91E603, 8'h7B},  // mixed
        {64'h8081807F80818081, 64'h7F807F81807F807E, 8'h80}   // small signed rounding
    };

    function automatic int byte_of(input logic [63:0] w, input int i);
        return int'(w[8*i +: 8]);
    endfunction

    function automatic int rshift5(input int v);
        return v >>> 5;
    endfunction

    function automatic int ref_pix(input logic [63:0] ab, input logic [63:0] lf,
                                   input logic [7:0] cr, input int x, input int y);
        int h, v, b, c, a, p;
        h = 4*(byte_of(ab,7)-int'(cr)) + 3*(byte_of(ab,6)-byte_of(ab,0))
          + 2*(byte_of(ab,5)-byte_of(ab,1)) + (byte_of(ab,4)-byte_of(ab,2));
        v = 4*(byte_of(lf,7)-int'(cr)) + 3*(byte_of(lf,6)-byte_of(lf,0))
          + 2*(byte_of(lf,5)-byte_of(lf,1)) + (byte_of(lf,4)-byte_of(lf,2));
        b = rshift5(17*h + 16);
        c = rshift5(17*v + 16);
        a = 16*(byte_of(ab,7) + byte_of(lf,7));
        p = rshift5(a + b*(x-3) + c*(y-3) + 16);
        if (p < 0) p = 0;
        if (p > 255) p = 255;
        return p;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_row(input logic [135:0] v, input int y);
        logic [63:0] r;
        for (int x = 0; x < 8; x++)
            r[8*x +: 8] = 8'(ref_pix(v[135:72], v[71:8], v[7:0], x, y));
        return r;
    endfunction

    // Run one block; optionally inject a start with other data at row 3.
    task automatic run_block(input logic [135:0] v, input bit inject, input logic [135:0] other);
        @(negedge clk);
        {above_in, left_in, corner_in} = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 no row in calc cycle", {63'b0, row_valid}, 64'd0);
        check("R10 busy after accept", {63'b0, busy}, 64'd1);
        @(negedge clk);
        for (int y = 0; y < 8; y++) begin
            check("R7 row_valid", {63'b0, row_valid}, 64'd1);
            check("R7 row_idx", {61'b0, row_idx}, 64'(y));
            check("R5 R6 row pixels (R2 R3 R4)", row_pix, ref_row(v, y));
            check("R8 done only on last row", {63'b0, done}, {63'b0, (y == 7)});
            if (inject && y == 3) begin
                {above_in, left_in, corner_in} = other;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R10 idle after last row", {63'b0, busy}, 64'd0);
        check("R9 no extra block", {63'b0, row_valid}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        above_in = '0;
        left_in = '0;
        corner_in = '0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {63'b0, row_valid}, 64'd0);
        check("R1 done in reset", {63'b0, done}, 64'd0);
        check("R1 busy in reset", {63'b0, busy}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {62'b0, busy, row_valid}, 64'd0);

        for (int i = 0; i < NVEC; i++)
            run_block(VEC[i], 1'b0, '0);

        // R9: mid-block start with different data is ignored
        run_block(VEC[1], 1'b1, VEC[3]);
        // R9: the ignored data must not leak into the next accepted block
        run_block(VEC[4], 1'b0, '0);

        // R7: back-to-back after idle with start held high
        @(negedge clk);
        {above_in, left_in, corner_in} = VEC[2];
        start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 first row after held start", {61'b0, row_idx, 1'b0, row_valid}, 64'h1);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 idle after held start block", {63'b0, busy}, 64'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule